// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block steers instruction fetch in a five-stage in-order pipeline. It resolves conditional branches while they sit in decode, using a local comparator on the two source operands and a local adder for the target. It owns the fetch address register. The decode stage gives it the branch kind, the operand values, a sign-extended offset and the address of the instruction being decoded.

In return the block produces three things: the address to fetch next cycle, a stall flag that marks the current fetch slot as empty, and a squash flag that tells the fetch/decode register to clear the valid bit of the instruction fetched this cycle. A static policy input picks how the one cycle between fetch and resolution is spent:

- Hold fetch until the outcome is known.
- Keep fetching sequentially and discard the wrong instruction when the branch is taken.
- Always execute the one instruction after the branch, as a delay slot.

A saturating counter totals the fetch cycles lost to stalls and squashes, so that penalty totals can be compared across policies.

Top module: `dec_branch_unit`

## Requirements
- R1: While reset is low and after it releases, fetch_pc equals the reset address (0x0000_1000 by default), lost_cycles is zero, and with no valid decode both fetch_stall and fetch_squash are low.
- R2: dec_kind encoding: 0 = not a branch, 1 = taken when src_a equals src_b, 2 = taken when they differ, 3 = taken when src_a is non-zero (src_b ignored).
- R3: The taken target is dec_pc + 4 + dec_offset, wrapping modulo 2^32.
- R4: When decode is not valid or dec_kind is 0, fetch_stall and fetch_squash are low and fetch_pc advances by 4 on the next edge.
- R5: Policy 0 (hold) with a valid branch in decode: fetch_stall is high, fetch_squash is low, and the next fetch_pc is the target if taken, else dec_pc + 4. Policy 3 behaves as policy 0. Stall and squash are never high together.
- R6: Policy 1 (sequential guess) with a not-taken branch: no stall, no squash, and fetch_pc advances by 4.
- R7: Policy 1 with a taken branch: fetch_squash is high, fetch_stall is low, and the next fetch_pc is the target.
- R8: Policy 2 (delay slot): fetch_stall and fetch_squash stay low. The next fetch_pc is the target if taken, else fetch_pc + 4, so the instruction after the branch always reaches decode.
- R9: lost_cycles rises by one on each edge where fetch_stall or fetch_squash was high. It saturates at its maximum value and otherwise holds.
- R10: In a loop whose closing branch is taken K-1 times and then falls through, the lost total is K under policy 0, K-1 under policy 1 and 0 under policy 2. The instruction after the branch reaches decode K times under policy 2 and once otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Branch policy: 0 hold, 1 sequential guess, 2 delay slot, 3 as 0 |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_kind | input | 2 | Branch kind of the decoded instruction (see R2) |
| dec_pc | input | 32 | Address of the decoded instruction |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| dec_offset | input | 32 | Sign-extended branch offset in bytes |
| fetch_pc | output | 32 | Address fetched this cycle |
| next_pc | output | 32 | Address to fetch on the next cycle |
| fetch_stall | output | 1 | The fetch slot this cycle is empty |
| fetch_squash | output | 1 | Clear the valid bit of the instruction fetched this cycle |
| lost_cycles | output | 16 | Saturating count of lost fetch cycles |

## Verification
The assertions assume that the policy and decode fields are settled and free of unknowns at each rising edge. They do not assume that dec_pc is the fetch address minus four. The exhaustive sweep changes inputs only on falling edges and deliberately pairs arbitrary decode addresses with the live fetch address, including a target that wraps past 2^32. The loop runs instead model the fetch/decode register from the block's own stall and squash outputs, so the decode address always trails fetch the way a real pipeline would.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int PC_W = 32;
  localparam int INSN_BYTES = 4;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2,
    BK_NZ   = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    POL_HOLD = 2'd0,
    POL_SEQ  = 2'd1,
    POL_SLOT = 2'd2,
    POL_RSVD = 2'd3
  } pol_e;

  // Condition evaluation for the decoded branch kind.
  function automatic logic cond_met(input br_kind_e k,
                                    input logic [PC_W-1:0] a,
                                    input logic [PC_W-1:0] b);
    logic same;
    same = (a == b);
    case (k)
      BK_EQ:   return same;
      BK_NE:   return !same;
      BK_NZ:   return (a != '0);
      default: return 1'b0;
    endcase
  endfunction

  // Sequential successor of an address.
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INSN_BYTES);
  endfunction

  // Taken target: successor of the branch plus offset, wrapping.
  function automatic logic [PC_W-1:0] taken_target(input logic [PC_W-1:0] pc,
                                                   input logic [PC_W-1:0] off);
    return seq_next(pc) + off;
  endfunction

  function automatic logic is_hold(input pol_e p);
    return (p == POL_HOLD) || (p == POL_RSVD);
  endfunction
endpackage

// File: rtl/dbu_cond.sv
module dbu_cond
  import dbu_pkg::*;
#(
  parameter int W = PC_W
) (
  input  logic         valid,
  input  br_kind_e     kind,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         active,
  output logic         taken
);
  assign active = valid && (kind != BK_NONE);
  assign taken  = active && cond_met(kind, op_a, op_b);
endmodule

// File: rtl/dbu_target.sv
module dbu_target
  import dbu_pkg::*;
#(
  parameter int W = PC_W
) (
  input  logic [W-1:0] br_pc,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] cur_fetch,
  output logic [W-1:0] tgt,
  output logic [W-1:0] fall,
  output logic [W-1:0] seq
);
  assign tgt  = taken_target(br_pc, offset);
  assign fall = seq_next(br_pc);
  assign seq  = seq_next(cur_fetch);
endmodule

// File: rtl/dbu_steer.sv
module dbu_steer
  import dbu_pkg::*;
#(
  parameter int W = PC_W
) (
  input  pol_e         pol,
  input  logic         active,
  input  logic         taken,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] seq,
  output logic [W-1:0] nxt,
  output logic         stall,
  output logic         squash
);
  always_comb begin
    stall  = 1'b0;
    squash = 1'b0;
    nxt    = seq;
    if (active) begin
      if (is_hold(pol)) begin
        stall = 1'b1;
        nxt   = taken ? tgt : fall;
      end else if (pol == POL_SEQ) begin
        squash = taken;
        if (taken) nxt = tgt;
      end else begin
        if (taken) nxt = tgt;
      end
    end
  end
endmodule

// File: rtl/dbu_penalty.sv
module dbu_penalty #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (bump && (cnt_q != TOP)) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dec_branch_unit.sv
module dec_branch_unit
  import dbu_pkg::*;
#(
  parameter int              XW       = PC_W,
  parameter int              CNT_W    = 16,
  parameter logic [XW-1:0]   RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             dec_valid,
  input  logic [1:0]       dec_kind,
  input  logic [XW-1:0]    dec_pc,
  input  logic [XW-1:0]    src_a,
  input  logic [XW-1:0]    src_b,
  input  logic [XW-1:0]    dec_offset,
  output logic [XW-1:0]    fetch_pc,
  output logic [XW-1:0]    next_pc,
  output logic             fetch_stall,
  output logic             fetch_squash,
  output logic [CNT_W-1:0] lost_cycles
);
  // Named internal events, brought out for the checker.
  logic          br_active;
  logic          br_taken;
  logic [XW-1:0] tgt_pc;
  logic [XW-1:0] fall_pc;
  logic [XW-1:0] seq_pc;
  logic [XW-1:0] pc_q;
  logic          lose_slot;

  dbu_cond #(.W(XW)) u_cond (
    .valid  (dec_valid),
    .kind   (br_kind_e'(dec_kind)),
    .op_a   (src_a),
    .op_b   (src_b),
    .active (br_active),
    .taken  (br_taken)
  );

  dbu_target #(.W(XW)) u_tgt (
    .br_pc     (dec_pc),
    .offset    (dec_offset),
    .cur_fetch (pc_q),
    .tgt       (tgt_pc),
    .fall      (fall_pc),
    .seq       (seq_pc)
  );

  dbu_steer #(.W(XW)) u_steer (
    .pol    (pol_e'(policy)),
    .active (br_active),
    .taken  (br_taken),
    .tgt    (tgt_pc),
    .fall   (fall_pc),
    .seq    (seq_pc),
    .nxt    (next_pc),
    .stall  (fetch_stall),
    .squash (fetch_squash)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= next_pc;
  end

  assign fetch_pc  = pc_q;
  assign lose_slot = fetch_stall | fetch_squash;

  dbu_penalty #(.W(CNT_W)) u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (lose_slot),
    .count (lost_cycles)
  );
endmodule

// File: rtl/dec_branch_unit_chk.sv
module dec_branch_unit_chk #(
  parameter int XW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy,
  input logic             br_active,
  input logic             br_taken,
  input logic [XW-1:0]    fetch_pc,
  input logic             fetch_stall,
  input logic             fetch_squash,
  input logic [CNT_W-1:0] lost_cycles
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !br_active |-> (!fetch_stall && !fetch_squash));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !br_active |=> fetch_pc == $past(fetch_pc) + XW'(4));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_stall && fetch_squash));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_active && (policy == 2'd0 || policy == 2'd3)) |-> fetch_stall);

  p_seq_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_active && !br_taken && policy == 2'd1) |-> (!fetch_stall && !fetch_squash));

  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_active && br_taken && policy == 2'd1) |-> fetch_squash);

  p_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd2) |-> (!fetch_stall && !fetch_squash));

  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetch_stall || fetch_squash) && lost_cycles != TOP) |=>
      lost_cycles == $past(lost_cycles) + 1'b1);

  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_stall || fetch_squash) |=> $stable(lost_cycles));
endmodule

bind dec_branch_unit dec_branch_unit_chk #(.XW(XW), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .policy       (policy),
  .br_active    (br_active),
  .br_taken     (br_taken),
  .fetch_pc     (fetch_pc),
  .fetch_stall  (fetch_stall),
  .fetch_squash (fetch_squash),
  .lost_cycles  (lost_cycles)
);

// File: tb/dec_branch_unit_bench.sv
module dec_branch_unit_bench;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_kind = 2'd0;
  logic [31:0] dec_pc = '0, src_a = '0, src_b = '0, dec_offset = '0;
  logic [31:0] fetch_pc, next_pc;
  logic        fetch_stall, fetch_squash;
  logic [15:0] lost_cycles;
  logic [31:0] fpc_s, npc_s;
  logic        stall_s, squash_s;
  logic [2:0]  lost_s;

  int total = 0;
  int bad = 0;
  int lost_model = 0;

  always #2 clk = ~clk;

  dec_branch_unit u_dec_branch_unit (
    .clk(clk), .rst_n(rst_n), .policy(policy), .dec_valid(dec_valid),
    .dec_kind(dec_kind), .dec_pc(dec_pc), .src_a(src_a), .src_b(src_b),
    .dec_offset(dec_offset), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .fetch_stall(fetch_stall), .fetch_squash(fetch_squash),
    .lost_cycles(lost_cycles)
  );

  dec_branch_unit #(.CNT_W(3)) u_small (
    .clk(clk), .rst_n(rst_n), .policy(policy), .dec_valid(dec_valid),
    .dec_kind(dec_kind), .dec_pc(dec_pc), .src_a(src_a), .src_b(src_b),
    .dec_offset(dec_offset), .fetch_pc(fpc_s), .next_pc(npc_s),
    .fetch_stall(stall_s), .fetch_squash(squash_s), .lost_cycles(lost_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit b_taken(input int kind, input logic [31:0] a, input logic [31:0] b);
    if (kind == 1) return a == b;
    if (kind == 2) return a != b;
    if (kind == 3) return a != 32'd0;
    return 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dec_valid = 1'b0; dec_kind = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lost_model = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 fetch_pc", fetch_pc, BASE);
    check("R1 lost", {16'd0, lost_cycles}, 32'd0);
    check("R1 stall", {31'd0, fetch_stall}, 32'd0);
    check("R1 squash", {31'd0, fetch_squash}, 32'd0);

    // Exhaustive sweep: policy x kind x operand pattern x offset case x valid.
    for (int pol = 0; pol < 4; pol++) begin
      for (int kind = 0; kind < 4; kind++) begin
        for (int pat = 0; pat < 4; pat++) begin
          for (int oc = 0; oc < 3; oc++) begin
            for (int v = 0; v < 2; v++) begin
              logic [31:0] a, b, dp, off, tgt, fpc, exp_next;
              bit act, tk, e_stall, e_squash;
              @(negedge clk);
              fpc = fetch_pc;
              a = (pat < 2) ? 32'd5 : 32'd0;
              b = (pat == 0) ? 32'd5 : (pat == 1) ? 32'd9 : (pat == 2) ? 32'd0 : 32'd7;
              if (oc == 0) begin dp = fpc - 32'd4; off = 32'h40; end
              else if (oc == 1) begin dp = fpc - 32'd4; off = 32'hFFFF_FFE0; end
              else begin dp = 32'hFFFF_FFF0; off = 32'h20; end
              policy = pol[1:0]; dec_valid = v[0]; dec_kind = kind[1:0];
              dec_pc = dp; src_a = a; src_b = b; dec_offset = off;
              act = (v == 1) && (kind != 0);
              tk = act && b_taken(kind, a, b);
              tgt = off + dp + 32'd4;
              e_stall = act && (pol == 0 || pol == 3);
              e_squash = act && (pol == 1) && tk;
              if (e_stall) exp_next = tk ? tgt : dp + 32'd4;
              else if (tk) exp_next = tgt;
              else exp_next = fpc + 32'd4;
              #1;
              if (!act) begin
                check("R4 stall", {31'd0, fetch_stall}, 32'd0);
                check("R4 squash", {31'd0, fetch_squash}, 32'd0);
              end else if (pol == 1) begin
                check(tk ? "R7 squash" : "R6 squash", {31'd0, fetch_squash}, {31'd0, e_squash});
                check(tk ? "R7 stall" : "R6 stall", {31'd0, fetch_stall}, 32'd0);
              end else if (pol == 2) begin
                check("R8 stall", {31'd0, fetch_stall}, 32'd0);
                check("R8 squash", {31'd0, fetch_squash}, 32'd0);
              end else begin
                check("R5 stall", {31'd0, fetch_stall}, 32'd1);
                check("R5 squash", {31'd0, fetch_squash}, 32'd0);
              end
              @(posedge clk);
              #1;
              if (e_stall || e_squash) lost_model++;
              check(act ? (oc == 2 ? "R3 wrap target" : "R2 R3 next fetch") : "R4 advance",
                    fetch_pc, exp_next);
              check("R9 lost", {16'd0, lost_cycles},
                    (lost_model > 65535) ? 32'd65535 : lost_model);
              check("R9 saturated lost", {29'd0, lost_s},
                    (lost_model > 7) ? 32'd7 : lost_model);
            end
          end
        end
      end
    end

    // Loop runs: 4-instruction body, closing branch taken K-1 times.
    for (int pol = 0; pol < 3; pol++) begin
      int K, L, iter, slot_cnt, body_cnt, cyc;
      logic fd_valid;
      logic [31:0] fd_pc, cap_pc;
      logic cap_lose;
      K = 5; L = 4; iter = 0; slot_cnt = 0; body_cnt = 0; cyc = 0;
      policy = pol[1:0];
      do_reset();
      fd_valid = 1'b0; fd_pc = '0;
      while (!(fd_valid && fd_pc == BASE + 32'd4 * L + 32'd4) && cyc < 300) begin
        dec_valid = fd_valid;
        dec_pc = fd_pc;
        dec_kind = 2'd0; src_a = '0; src_b = '0; dec_offset = '0;
        if (fd_valid && fd_pc == BASE + 32'd4 * (L - 1)) begin
          dec_kind = 2'd2;
          src_a = iter; src_b = K - 1;
          dec_offset = -(32'd4 * L);
          iter++;
        end
        if (fd_valid && fd_pc == BASE + 32'd4 * L) slot_cnt++;
        if (fd_valid && fd_pc >= BASE && fd_pc < BASE + 32'd4 * L) body_cnt++;
        #1;
        cap_pc = fetch_pc;
        cap_lose = fetch_stall | fetch_squash;
        @(posedge clk);
        #1;
        fd_valid = !cap_lose;
        fd_pc = cap_pc;
        @(negedge clk);
        cyc++;
      end
      dec_valid = 1'b0;
      check("R10 loop lost", {16'd0, lost_cycles},
            (pol == 0) ? K : (pol == 1) ? K - 1 : 0);
      check("R10 slot count R8", slot_cnt, (pol == 2) ? K : 1);
      check("R10 body count", body_cnt, K * L);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule